// File: doc/BRIEF.md
# Presettable Down Counter with Terminal Count

This block is a parameterised synchronous binary down counter with one active-low terminal-count output. The register falls by one on every rising clock edge while its active-low count enable is asserted, and holds while that enable is released. The output flag goes low while the value is zero and the enable is asserted. A clocked parallel load and an immediate, clock-free parallel load take their value from one data word. An asynchronous clear sets the register to full scale, not to zero.

A counter at zero with only the enable asserted wraps to full scale on the next edge, so a free-running stage divides the clock by 2^WIDTH. Longer dividers or programmable delays are built by chaining stages. One stage's terminal-count output drives the count enable of the next, and all stages share one clock. Every control input is active low.

Top module: `dcount_top`

## Requirements
- R1: With `clear_n`, `async_load_n` and `sync_load_n` high and `count_en_n` low, each rising clock edge lowers `count_q` by exactly one.
- R2: With `count_en_n` high and no load or clear active, `count_q` keeps its value across clock edges.
- R3: `zero_n` is low exactly when `count_q` is zero and `count_en_n` is low, in the same cycle with no register stage. With the value at zero, raising `count_en_n` drives `zero_n` high.
- R4: In free counting, `zero_n` is low for exactly one clock period out of every 2^WIDTH periods.
- R5: When `sync_load_n` is low and no asynchronous control is active, the next rising edge loads `load_value` into `count_q`, whatever the state of `count_en_n`.
- R6: When `async_load_n` is low, `count_q` takes `load_value` with no clock edge, and later edges neither count nor perform the clocked load.
- R7: When `clear_n` is low, `count_q` becomes all ones at once, with no clock edge, and stays there whatever the other inputs do. The clear has the highest priority.
- R8: A value of zero with only `count_en_n` asserted wraps to all ones (255 at WIDTH=8) on the next edge.
- R9: Two stages with `zero_n` of the low stage wired to `count_en_n` of the high stage count down together as one counter of twice the width. The high stage's `zero_n` goes low only when both stages are zero.
- R10: After a clear, `count_q` is all ones and `zero_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge |
| clear_n | input | 1 | Asynchronous clear to full scale, active low |
| async_load_n | input | 1 | Immediate parallel load, active low |
| sync_load_n | input | 1 | Clocked parallel load, active low |
| count_en_n | input | 1 | Count enable, also gates the zero flag, active low |
| load_value | input | WIDTH | Parallel load data |
| count_q | output | WIDTH | Current counter value |
| zero_n | output | 1 | Terminal count, low at zero while enabled |

## Verification
The bench builds one stage with the default WIDTH of 8. This makes the full 256-edge wrap cycle and its single low-going terminal-count period short enough to check edge by edge. It also builds two stages with WIDTH of 4 chained through the terminal-count output. Their combined 8-bit value is compared with a plain down count across several low-nibble borrows and a wrap through zero.

// File: rtl/dcount_pkg.sv
package dcount_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_SLOAD = 2'd2
  } dc_op_e;

endpackage

// File: rtl/dcount_ctrl.sv
module dcount_ctrl
  import dcount_pkg::*;
(
  input  logic   sync_load_n,
  input  logic   count_en_n,
  output dc_op_e op
);

  // Clocked load outranks counting; counting outranks holding.
  always_comb begin
    if (!sync_load_n)      op = OP_SLOAD;
    else if (!count_en_n)  op = OP_COUNT;
    else                   op = OP_HOLD;
  end

endmodule

// File: rtl/dcount_next.sv
module dcount_next
  import dcount_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_value,
  input  dc_op_e           op,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  logic at_zero;
  assign at_zero = (cur == '0);

  always_comb begin
    unique case (op)
      OP_SLOAD: nxt = load_value;
      OP_COUNT: nxt = at_zero ? FULL : (cur - ONE);
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/dcount_zero.sv
module dcount_zero #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             count_en_n,
  output logic             zero_n
);

  assign zero_n = ~((cur == '0) & ~count_en_n);

endmodule

// File: rtl/dcount_top.sv
module dcount_top
  import dcount_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             async_load_n,
  input  logic             sync_load_n,
  input  logic             count_en_n,
  input  logic [WIDTH-1:0] load_value,
  output logic [WIDTH-1:0] count_q,
  output logic             zero_n
);

  localparam logic [WIDTH-1:0] FULL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE  = {{(WIDTH-1){1'b0}}, 1'b1};

  dc_op_e           op;
  logic [WIDTH-1:0] nxt;

  dcount_ctrl u_ctrl (
    .sync_load_n (sync_load_n),
    .count_en_n  (count_en_n),
    .op          (op)
  );

  dcount_next #(.WIDTH(WIDTH)) u_next (
    .cur        (count_q),
    .load_value (load_value),
    .op         (op),
    .nxt        (nxt)
  );

  dcount_zero #(.WIDTH(WIDTH)) u_zero (
    .cur        (count_q),
    .count_en_n (count_en_n),
    .zero_n     (zero_n)
  );

  // Clear outranks the immediate load; both outrank the clocked path.
  always_ff @(posedge clk or negedge clear_n or negedge async_load_n) begin
    if (!clear_n)           count_q <= FULL;
    else if (!async_load_n) count_q <= load_value;
    else                    count_q <= nxt;
  end

  // R1
  a_r1_decrement: assert property (@(posedge clk) disable iff (!clear_n || !async_load_n)
    (sync_load_n && !count_en_n && count_q != '0) |=> (count_q == $past(count_q) - ONE));

  // R2
  a_r2_hold: assert property (@(posedge clk) disable iff (!clear_n || !async_load_n)
    (sync_load_n && count_en_n) |=> $stable(count_q));

  // R5
  a_r5_sync_load: assert property (@(posedge clk) disable iff (!clear_n || !async_load_n)
    (!sync_load_n) |=> (count_q == $past(load_value)));

  // R6
  a_r6_async_load: assert property (@(posedge clk) disable iff (!clear_n)
    (!async_load_n) |-> (count_q == load_value));

  // R7
  a_r7_clear_full: assert property (@(posedge clk)
    (!clear_n) |-> (count_q == FULL));

  // R8
  a_r8_wrap: assert property (@(posedge clk) disable iff (!clear_n || !async_load_n)
    (sync_load_n && !count_en_n && count_q == '0) |=> (count_q == FULL));

endmodule

// File: tb/tb_dcount_top.sv
`timescale 1ns/100ps
module tb_dcount_top;

  typedef struct {
    int         sel;
    logic [7:0] exp_cnt;
    logic       exp_zero;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       clear_n = 1'b1;
  logic       async_load_n = 1'b1;
  logic       sync_load_n = 1'b1;
  logic       count_en_n = 1'b1;
  logic [7:0] load_value = 8'h00;
  logic [7:0] count_q;
  logic       zero_n;

  logic       c_load_n = 1'b1;
  logic [3:0] lo_q, hi_q;
  logic       lo_zero_n, hi_zero_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t q[$];

  always #5 clk = ~clk;

  dcount_top #(.WIDTH(8)) dut (
    .clk(clk), .clear_n(clear_n), .async_load_n(async_load_n),
    .sync_load_n(sync_load_n), .count_en_n(count_en_n),
    .load_value(load_value), .count_q(count_q), .zero_n(zero_n)
  );

  dcount_top #(.WIDTH(4)) u_lo (
    .clk(clk), .clear_n(clear_n), .async_load_n(1'b1),
    .sync_load_n(c_load_n), .count_en_n(1'b0),
    .load_value(load_value[3:0]), .count_q(lo_q), .zero_n(lo_zero_n)
  );

  dcount_top #(.WIDTH(4)) u_hi (
    .clk(clk), .clear_n(clear_n), .async_load_n(1'b1),
    .sync_load_n(c_load_n), .count_en_n(lo_zero_n),
    .load_value(load_value[7:4]), .count_q(hi_q), .zero_n(hi_zero_n)
  );

  task automatic chk_int(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares them with the outputs.
  initial begin
    item_t it;
    logic [7:0] ac;
    logic       az;
    forever begin
      wait (q.size() > 0);
      it = q.pop_front();
      if (it.sel == 0) begin ac = count_q; az = zero_n; end
      else             begin ac = {hi_q, lo_q}; az = hi_zero_n; end
      checks++;
      if (ac !== it.exp_cnt || az !== it.exp_zero) begin
        fails++;
        $display("FAIL %s: actual count=%0d zero_n=%b expected count=%0d zero_n=%b",
                 it.tag, ac, az, it.exp_cnt, it.exp_zero);
      end
    end
  end

  task automatic expect_item(input int sel, input logic [7:0] c, input logic z, input string tag);
    item_t it;
    it.sel = sel; it.exp_cnt = c; it.exp_zero = z; it.tag = tag;
    q.push_back(it);
    #1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic zexp(input logic [7:0] v, input logic en_n);
    return !(v == 8'd0 && !en_n);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] m;
    int lows;
    #1 clear_n = 1'b0;
    #1;
    expect_item(0, 8'hFF, 1'b1, "R10 clear state");
    expect_item(0, 8'hFF, 1'b1, "R7 clear without edge");
    sync_load_n = 1'b0; count_en_n = 1'b0; load_value = 8'h33;
    tick(); tick();
    expect_item(0, 8'hFF, 1'b1, "R7 clear overrides load and count");
    sync_load_n = 1'b1;
    clear_n = 1'b1;
    m = 8'hFF;
    // R1 decrement
    for (int i = 0; i < 3; i++) begin
      tick(); m = m - 8'd1;
      expect_item(0, m, 1'b1, "R1 decrement");
    end
    // R2 hold
    count_en_n = 1'b1;
    tick(); tick();
    expect_item(0, m, 1'b1, "R2 hold while disabled");
    // R5 clocked load with enable released, then with enable asserted
    load_value = 8'd5; sync_load_n = 1'b0;
    tick(); m = 8'd5;
    expect_item(0, m, 1'b1, "R5 load while disabled");
    load_value = 8'd3; count_en_n = 1'b0;
    tick(); m = 8'd3;
    expect_item(0, m, 1'b1, "R5 load over counting");
    sync_load_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      tick(); m = m - 8'd1;
      expect_item(0, m, zexp(m, 1'b0), "R1 count toward zero");
    end
    expect_item(0, 8'd0, 1'b0, "R3 zero flag at zero");
    count_en_n = 1'b1; #1;
    expect_item(0, 8'd0, 1'b1, "R3 flag gated by enable");
    tick();
    expect_item(0, 8'd0, 1'b1, "R2 hold at zero");
    count_en_n = 1'b0; #1;
    expect_item(0, 8'd0, 1'b0, "R3 flag returns with enable");
    tick(); m = 8'hFF;
    expect_item(0, m, 1'b1, "R8 wrap to full scale");
    // R4 / R8 full cycle
    lows = 0;
    for (int i = 0; i < 256; i++) begin
      tick(); m = m - 8'd1;
      if (zero_n == 1'b0) lows++;
    end
    chk_int("R4 zero flag periods per cycle", lows, 1);
    expect_item(0, m, 1'b1, "R8 value after 256 edges");
    // R6 immediate load
    load_value = 8'h5A; async_load_n = 1'b0; #2;
    expect_item(0, 8'h5A, 1'b1, "R6 load without edge");
    sync_load_n = 1'b0;
    tick(); tick();
    expect_item(0, 8'h5A, 1'b1, "R6 overrides clocked load and count");
    sync_load_n = 1'b1;
    // R7 clear beats immediate load
    clear_n = 1'b0; #1;
    expect_item(0, 8'hFF, 1'b1, "R7 clear beats immediate load");
    tick();
    expect_item(0, 8'hFF, 1'b1, "R7 clear held over edge");
    async_load_n = 1'b1;
    tick();
    clear_n = 1'b1;
    m = 8'hFF;
    tick(); m = m - 8'd1;
    expect_item(0, m, 1'b1, "R1 count after clear released");
    // R9 chained stages
    load_value = 8'h12; c_load_n = 1'b0;
    tick(); m = 8'h12;
    expect_item(1, m, 1'b1, "R9 chain load");
    c_load_n = 1'b1;
    for (int i = 0; i < 24; i++) begin
      tick(); m = m - 8'd1;
      expect_item(1, m, (m != 8'd0), "R9 chained count");
    end
    wait (q.size() == 0);
    #2;
    finish_run();
  end

endmodule